// File: doc/BRIEF.md
# Repeating Input Port FIFO

This block buffers the words that arrive at one input port of a spatial accelerator. The consumer on the far side can take each word more than once. Before it opens a stream on the port, the host may load a replay count. When the stream begins, the port takes that count and ties it to every word the stream pushes. The consumer then sees each word that many times in a row, and only after the last of those repetitions is accepted does the word leave the buffer.

Opening a stream returns the host-side count to one. A later stream is therefore presented plainly unless the host loads a new count. A common use is to forward one scalar, such as a normalisation factor, into the port with a count equal to the loop length. Each iteration of an elementwise loop then reads the same value without fetching it again.

Each buffered word carries its own count. Several streams with different counts can therefore wait in the buffer together.

Top module: `repeat_port_fifo`

## Requirements
- R1: Out of reset, `out_valid` is 0, `in_ready` is 1 and the host count is 1. Words pushed before any stream start, or in a stream started without a count write, appear exactly once.
- R2: A `cfg_wr` pulse loads `cfg_count` into the host count. A following `stream_start` captures that value. Every word of that stream then appears on `out_data` exactly that many times in consecutive accepted transfers, and after the final one `out_valid` falls if nothing else is buffered.
- R3: With a count of 2, the pushed words 1, 2, 3 are delivered as 1, 1, 2, 2, 3, 3.
- R4: A `stream_start` without a `cfg_wr` in the same cycle returns the host count to 1. The next stream started without a new write appears unrepeated.
- R5: A captured count of 0 behaves as a count of 1.
- R6: Each word keeps the count of the stream it was pushed under, even when a later stream with a different count is pushed before the earlier words drain.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged on the next cycle. The head word stays in place until its final repetition is accepted.
- R8: With DEPTH words stored, `in_ready` is 0. A word offered while the buffer is full is neither stored nor lost: it is accepted exactly once after space frees.
- R9: A single word pushed with a count of 200 is delivered 200 times, with no word of the next stream in between.
- R10: When `cfg_wr` and `stream_start` occur in the same cycle, the stream captures the previous host count, and the written value becomes the count for the next stream.
- R11: A word pushed in the same cycle as `stream_start` belongs to the newly started stream and uses its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Host write strobe for the replay count |
| cfg_count | input | CNT_W | Replay count to load |
| stream_start | input | 1 | Starts a new stream; captures the host count and re-arms it to 1 |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Buffer has space |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | A buffered word is being presented |
| out_ready | input | 1 | Consumer accepts one repetition |
| out_data | output | DATA_W | Presented word |

## Verification
Some properties are checked on every cycle. The replay index never reaches the head word's count. A stalled head keeps its value and its valid. The occupancy never exceeds DEPTH, and the write pointer stays put while the buffer is full. The host count re-arms to one on a plain stream start, and a captured count is never zero.

Other behaviour only shows across whole scenarios:
- the exact delivered sequence for each count;
- a count of 0 acting as one;
- mixed-count streams sharing the buffer;
- the same-cycle orderings of write, start and push;
- a long scalar replay;
- the full buffer that holds back one word without dropping or duplicating it.

The bench checks these against a scoreboard whose words are expanded by a model of the host count.

// File: rtl/rpf_pkg.sv
`timescale 1ns/1ps
package rpf_pkg;

    // A replay count of zero is served as a single presentation.
    function automatic int unsigned eff_count(input int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

    // Index width for a buffer of the given depth (at least one bit).
    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Position of the head word within its replay sequence.
    typedef enum logic [1:0] {
        HEAD_NONE  = 2'd0,
        HEAD_AGAIN = 2'd1,
        HEAD_LAST  = 2'd2
    } head_phase_e;

endpackage

// File: rtl/rpf_count_reg.sv
`timescale 1ns/1ps
module rpf_count_reg
    import rpf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             stream_start,
    output logic [CNT_W-1:0] push_count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] arm_q;      // host-side count waiting for the next stream
    logic [CNT_W-1:0] live_q;     // count of the stream currently being pushed
    logic [CNT_W-1:0] armed_eff;

    assign armed_eff = CNT_W'(eff_count(32'(arm_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= ONE;
            live_q <= ONE;
        end else begin
            if (cfg_wr)
                arm_q <= cfg_count;
            else if (stream_start)
                arm_q <= ONE;
            if (stream_start)
                live_q <= armed_eff;
        end
    end

    // A push in the start cycle already belongs to the new stream.
    assign push_count = stream_start ? armed_eff : live_q;

    // R4
    rearm_to_one_chk: assert property (@(posedge clk) disable iff (rst)
        (stream_start && !cfg_wr) |=> (arm_q == ONE));

    // R5
    live_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        live_q != '0);

    // R10
    write_with_start_chk: assert property (@(posedge clk) disable iff (rst)
        (stream_start && cfg_wr) |=> (arm_q == $past(cfg_count)) && (live_q == $past(armed_eff)));

endmodule

// File: rtl/rpf_store.sv
`timescale 1ns/1ps
module rpf_store
    import rpf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CNT_W-1:0]  push_count,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  head_count
);

    localparam int PTR_W = ptr_bits(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] OCC_FULL  = OCC_W'(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  count;
    } entry_t;

    entry_t            slots [DEPTH];
    logic [PTR_W-1:0]  wr_q;
    logic [PTR_W-1:0]  rd_q;
    logic [OCC_W-1:0]  occ_q;
    entry_t            head;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            slots[wr_q] <= '{data: push_data, count: push_count};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) wr_q <= step(wr_q);
            if (pop)  rd_q <= step(rd_q);
            case ({push, pop})
                2'b10:   occ_q <= occ_q + OCC_W'(1);
                2'b01:   occ_q <= occ_q - OCC_W'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign full       = (occ_q == OCC_FULL);
    assign empty      = (occ_q == '0);
    assign head       = slots[rd_q];
    assign head_data  = head.data;
    assign head_count = head.count;

    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_FULL);

    // R8
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full && (wr_q == $past(wr_q)));

endmodule

// File: rtl/rpf_replay.sv
`timescale 1ns/1ps
module rpf_replay
    import rpf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_valid,
    input  logic [CNT_W-1:0] head_count,
    input  logic             out_ready,
    output logic             pop
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] idx_q;   // repetitions of the head already accepted
    logic             accept;
    head_phase_e      phase;

    always_comb begin
        if (!head_valid)
            phase = HEAD_NONE;
        else if (idx_q == head_count - ONE)
            phase = HEAD_LAST;
        else
            phase = HEAD_AGAIN;
    end

    assign accept = head_valid && out_ready;
    assign pop    = accept && (phase == HEAD_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (pop)
            idx_q <= '0;
        else if (accept)
            idx_q <= idx_q + ONE;
    end

    // R2
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> (idx_q < head_count));

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !out_ready) |=> head_valid && $stable(head_count) && $stable(idx_q));

    // R7
    keep_until_final_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && phase == HEAD_AGAIN) |=> head_valid && (idx_q == $past(idx_q) + ONE));

endmodule

// File: rtl/repeat_port_fifo.sv
`timescale 1ns/1ps
module repeat_port_fifo
    import rpf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              stream_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [CNT_W-1:0] push_count;
    logic [CNT_W-1:0] head_count;
    logic             full;
    logic             empty;
    logic             push;
    logic             pop;

    rpf_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_count    (cfg_count),
        .stream_start (stream_start),
        .push_count   (push_count)
    );

    rpf_store #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (in_data),
        .push_count (push_count),
        .pop        (pop),
        .full       (full),
        .empty      (empty),
        .head_data  (out_data),
        .head_count (head_count)
    );

    rpf_replay #(.CNT_W(CNT_W)) u_replay (
        .clk        (clk),
        .rst        (rst),
        .head_valid (out_valid),
        .head_count (head_count),
        .out_ready  (out_ready),
        .pop        (pop)
    );

    assign in_ready  = !full;
    assign push      = in_valid && !full;
    assign out_valid = !empty;

    // R7
    stalled_output_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

endmodule

// File: tb/repeat_port_fifo_test.sv
`timescale 1ns/1ps
module repeat_port_fifo_test;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic              stream_start = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Scoreboard and host-count model
    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    string             cur_tag = "R1";
    int                model_arm  = 1;
    int                model_live = 1;
    int                ready_mode = 0;   // 0 always, 1 pattern, 2 never
    logic [7:0]        lf = 8'hA5;
    bit                stall_prev = 1'b0;
    logic [DATA_W-1:0] stall_data = '0;

    repeat_port_fifo #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
        .stream_start(stream_start), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    function automatic int norm(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic expect_word(input logic [DATA_W-1:0] d);
        for (int k = 0; k < model_live; k++) begin
            exp_q.push_back(d);
            tag_q.push_back(cur_tag);
        end
    endtask

    task automatic cfg_write(input int v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_count = CNT_W'(v);
        model_arm = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start_stream();
        @(negedge clk);
        stream_start = 1'b1;
        model_live = norm(model_arm);
        model_arm  = 1;
        @(negedge clk);
        stream_start = 1'b0;
    endtask

    task automatic start_with_cfg(input int v);
        @(negedge clk);
        stream_start = 1'b1; cfg_wr = 1'b1; cfg_count = CNT_W'(v);
        model_live = norm(model_arm);
        model_arm  = v;
        @(negedge clk);
        stream_start = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic push(input logic [DATA_W-1:0] d);
        bit acc;
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        do begin
            #1;
            acc = in_ready;
            if (acc) expect_word(d);
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic start_and_push(input logic [DATA_W-1:0] d);
        @(negedge clk);
        stream_start = 1'b1; in_valid = 1'b1; in_data = d;
        model_live = norm(model_arm);
        model_arm  = 1;
        #1;
        chk(in_ready == 1'b1, "R11", "in_ready during start push", int'(in_ready), 1);
        expect_word(d);
        @(negedge clk);
        stream_start = 1'b0; in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R2", "no extra repetition after drain", int'(out_valid), 0);
    endtask

    // Monitor: sets the consumer ready at the falling edge, samples just before the rising edge.
    always @(negedge clk) begin
        if (rst) begin
            out_ready = 1'b0;
        end else begin
            case (ready_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = lf[0] | lf[3];
                default: out_ready = 1'b0;
            endcase
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            #2;
            if (stall_prev) begin
                chk(out_valid == 1'b1, "R7", "valid held while stalled", int'(out_valid), 1);
                chk(out_data == stall_data, "R7", "data held while stalled",
                    int'(out_data), int'(stall_data));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected output word", int'(out_data), -1);
                end else begin
                    automatic logic [DATA_W-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(out_data == e, t, "output word", int'(out_data), int'(e));
                end
            end
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R1: no start at all, then a start with no write
        cur_tag = "R1"; ready_mode = 1;
        push(16'h0011); push(16'h0022);
        start_stream();
        push(16'h0033);
        drain();

        // R3: count 2 on 1,2,3
        cur_tag = "R3";
        cfg_write(2); start_stream();
        push(16'd1); push(16'd2); push(16'd3);
        drain();

        // R4: re-armed to one
        cur_tag = "R4";
        start_stream();
        push(16'h0007); push(16'h0008);
        drain();

        // R5: zero count acts as one
        cur_tag = "R5";
        cfg_write(0); start_stream();
        push(16'h0009);
        drain();

        // R6: mixed counts resident together
        cur_tag = "R6"; ready_mode = 2;
        cfg_write(3); start_stream();
        push(16'h00A0); push(16'h00B0);
        cfg_write(2); start_stream();
        push(16'h00C0);
        ready_mode = 1;
        drain();

        // R10: write and start in the same cycle
        cur_tag = "R10";
        cfg_write(4);
        start_with_cfg(3);
        push(16'h0100);
        start_stream();
        push(16'h0200);
        drain();

        // R11: push in the start cycle
        cur_tag = "R11";
        cfg_write(2);
        start_and_push(16'h0300);
        push(16'h0301);
        drain();

        // R8: fill, offer one more while full, then release
        cur_tag = "R8"; ready_mode = 2;
        start_stream();
        for (int i = 0; i < DEPTH; i++) push(16'h0400 + 16'(i));
        fork
            push(16'h04FF);
            begin
                repeat (3) begin
                    @(negedge clk); #1;
                    chk(in_ready == 1'b0, "R8", "in_ready while full", int'(in_ready), 0);
                end
                ready_mode = 0;
            end
        join
        drain();

        // R9: scalar reused 200 times, then a plain word
        cur_tag = "R9"; ready_mode = 1;
        cfg_write(200); start_stream();
        push(16'h002A);
        start_stream();
        push(16'h002B);
        drain();

        chk(exp_q.size() == 0, "R2", "scoreboard empty at end", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule